// File: doc/BRIEF.md
# Chained Dual Watchpoint Comparator

This block watches a processor bus every clock cycle and raises a breakpoint request when a programmed condition is seen. It holds two watchpoint units. Each unit compares the bus address, the bus data word and a 9-bit attribute vector against value registers, and a mask register per field marks bits that take no part in the comparison. The attribute vector of a unit holds the access attributes from the bus, the unit's own external condition input, and two coupling terms.

Unit 1 couples into unit 0 in two ways. Its address/attribute hit appears in unit 0's vector in the same cycle as a range term, so both units can demand conditions at once (for example a lower and an upper address window). A chain flag, loaded with unit 1's data-hit result in every cycle where unit 1's address/attribute comparison hits, appears in unit 0's vector in later cycles, which gives conditions such as "break at this address only while that process identifier was last written". A plain register-write port programs both units. A unit only requests a break when its enable bit is set, and that bit has no mask.

Top module: `dwp_top`

## Requirements
- R1: A unit's address comparison hits when every bus address bit whose address-mask bit is 0 equals the address-value bit; mask bits set to 1 are ignored.
- R2: A unit's data comparison hits when every bus data bit whose data-mask bit is 0 equals the data-value bit.
- R3: The attribute vector bits 5:0 come from `bus_attr`: bit 0 write, bits 2:1 size, bit 3 access kind (0 instruction fetch, 1 data access), bit 4 privilege (0 User mode, 1 privileged), bit 5 locked.
- R4: Attribute bit 6 of unit n is `ext_cond[n]`; the other unit's external input has no effect on it.
- R5: Attribute bits 8:0 are compared with control value bits 8:0, and an attribute bit whose control-mask bit is 1 is ignored.
- R6: Control value bit 9 is the enable; a unit with enable 0 never causes a break, and no mask bit can stand in for it.
- R7: Attribute bit 7 of unit 0 is the chain flag. At each clock edge where unit 1's address and attribute comparisons both hit, the flag takes unit 1's data-hit result; otherwise it holds. Unit 1's bits 7 and 8 always read 0.
- R8: A write to unit 1's control value register clears the chain flag, and this clear wins over a load in the same cycle; reset also clears it.
- R9: Attribute bit 8 of unit 0 is unit 1's address-and-attribute hit in the same cycle.
- R10: `brk_req` is 1 in the cycle after each cycle in which an enabled unit has address, data and attribute hits, and 0 otherwise.
- R11: Reset (`rst_n` low) sets every register to 0, so both units are disabled and `brk_req` is 0.
- R12: With `cfg_we` high, `cfg_wdata` is written to the register of unit `cfg_unit` chosen by `cfg_idx` (0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value with enable at bit 9, 5 control mask); a write is used for comparisons from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Bus address of the current cycle |
| bus_data | input | DW | Bus data of the current cycle |
| bus_attr | input | 6 | Access attributes (write, size, kind, privilege, locked) |
| ext_cond | input | 2 | External condition, one bit per unit |
| cfg_we | input | 1 | Register write strobe |
| cfg_unit | input | 1 | Unit selected for the write |
| cfg_idx | input | 3 | Register selected for the write |
| cfg_wdata | input | WDW | Write data |
| brk_req | output | 1 | Registered breakpoint request |

## Verification
The hardest situation to reach is a write to unit 1's control value in the very cycle where unit 1's address comparison would load the chain flag, since only the following unit 0 hit shows which of the two won. The stimulus first sets the flag through a unit 1 hit, confirms it through a unit 0 break, then drives a second loading bus cycle together with the clearing write and probes unit 0 again. A behavioural model in the bench follows every cycle of directed scenarios and a long random phase that mixes register writes into bus traffic drawn from a small address pool so that hits, chain loads and range hits occur often.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
    localparam int ATTR_W    = 6;
    localparam int CTL_W     = 9;
    localparam int BIT_EXT   = 6;
    localparam int BIT_CHAIN = 7;
    localparam int BIT_RANGE = 8;
    localparam int NUM_UNITS = 2;

    typedef enum logic [2:0] {
        REG_AV = 3'd0,
        REG_AM = 3'd1,
        REG_DV = 3'd2,
        REG_DM = 3'd3,
        REG_CV = 3'd4,
        REG_CM = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/dwp_cfg_regs.sv
module dwp_cfg_regs
    import dwp_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int WDW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_idx,
    input  logic [WDW-1:0]   wr_data,
    output logic [AW-1:0]    addr_val,
    output logic [AW-1:0]    addr_msk,
    output logic [DW-1:0]    data_val,
    output logic [DW-1:0]    data_msk,
    output logic [CTL_W-1:0] ctl_val,
    output logic [CTL_W-1:0] ctl_msk,
    output logic             enable
);
    typedef struct packed {
        logic [AW-1:0]    av;
        logic [AW-1:0]    am;
        logic [DW-1:0]    dv;
        logic [DW-1:0]    dm;
        logic [CTL_W-1:0] cv;
        logic [CTL_W-1:0] cm;
        logic             en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_idx)
                REG_AV: cfg_d.av = wr_data[AW-1:0];
                REG_AM: cfg_d.am = wr_data[AW-1:0];
                REG_DV: cfg_d.dv = wr_data[DW-1:0];
                REG_DM: cfg_d.dm = wr_data[DW-1:0];
                REG_CV: begin
                    cfg_d.cv = wr_data[CTL_W-1:0];
                    cfg_d.en = wr_data[CTL_W];
                end
                REG_CM: cfg_d.cm = wr_data[CTL_W-1:0];
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign addr_val = cfg_q.av;
    assign addr_msk = cfg_q.am;
    assign data_val = cfg_q.dv;
    assign data_msk = cfg_q.dm;
    assign ctl_val  = cfg_q.cv;
    assign ctl_msk  = cfg_q.cm;
    assign enable   = cfg_q.en;
endmodule

// File: rtl/dwp_compare.sv
module dwp_compare
    import dwp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    data,
    input  logic [CTL_W-1:0] attr,
    input  logic [AW-1:0]    addr_val,
    input  logic [AW-1:0]    addr_msk,
    input  logic [DW-1:0]    data_val,
    input  logic [DW-1:0]    data_msk,
    input  logic [CTL_W-1:0] ctl_val,
    input  logic [CTL_W-1:0] ctl_msk,
    output logic             ac_hit,
    output logic             d_hit
);
    logic [AW-1:0]    addr_diff;
    logic [DW-1:0]    data_diff;
    logic [CTL_W-1:0] ctl_diff;

    always_comb begin
        addr_diff = (addr ^ addr_val) & ~addr_msk;
        data_diff = (data ^ data_val) & ~data_msk;
        ctl_diff  = (attr ^ ctl_val)  & ~ctl_msk;
        ac_hit    = (addr_diff == '0) && (ctl_diff == '0);
        d_hit     = (data_diff == '0);
    end
endmodule

// File: rtl/dwp_top.sv
module dwp_top
    import dwp_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int WDW = (AW > DW) ? AW : DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_data,
    input  logic [ATTR_W-1:0] bus_attr,
    input  logic [1:0]        ext_cond,
    input  logic              cfg_we,
    input  logic              cfg_unit,
    input  logic [2:0]        cfg_idx,
    input  logic [WDW-1:0]    cfg_wdata,
    output logic              brk_req
);
    typedef struct packed {
        logic chain;
        logic brk;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_UNITS-1:0] ac_hit;
    logic [NUM_UNITS-1:0] d_hit;
    logic [NUM_UNITS-1:0] en_vec;
    logic [NUM_UNITS-1:0] chain_in;
    logic [NUM_UNITS-1:0] range_in;
    logic                 chain_q;
    logic                 chain_clr;

    assign chain_q  = st_q.chain;
    assign chain_in = {1'b0, st_q.chain};
    assign range_in = {1'b0, ac_hit[1]};

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic [AW-1:0]    av, am;
        logic [DW-1:0]    dv, dm;
        logic [CTL_W-1:0] cv, cm;
        logic [CTL_W-1:0] attr_vec;
        logic             wr_sel;

        assign wr_sel   = cfg_we && (cfg_unit == 1'(u));
        assign attr_vec = {range_in[u], chain_in[u], ext_cond[u], bus_attr};

        dwp_cfg_regs #(.AW(AW), .DW(DW), .WDW(WDW)) regs_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel),
            .wr_idx   (cfg_idx),
            .wr_data  (cfg_wdata),
            .addr_val (av),
            .addr_msk (am),
            .data_val (dv),
            .data_msk (dm),
            .ctl_val  (cv),
            .ctl_msk  (cm),
            .enable   (en_vec[u])
        );

        dwp_compare #(.AW(AW), .DW(DW)) cmp_i (
            .addr     (bus_addr),
            .data     (bus_data),
            .attr     (attr_vec),
            .addr_val (av),
            .addr_msk (am),
            .data_val (dv),
            .data_msk (dm),
            .ctl_val  (cv),
            .ctl_msk  (cm),
            .ac_hit   (ac_hit[u]),
            .d_hit    (d_hit[u])
        );
    end

    assign chain_clr = cfg_we && cfg_unit && (cfg_idx == REG_CV);

    always_comb begin
        st_d     = st_q;
        st_d.brk = |(ac_hit & d_hit & en_vec);
        if (chain_clr)      st_d.chain = 1'b0;
        else if (ac_hit[1]) st_d.chain = d_hit[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk_req = st_q.brk;
endmodule

// File: rtl/dwp_checker.sv
module dwp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       cfg_unit,
    input logic [2:0] cfg_idx,
    input logic [1:0] ac_hit,
    input logic [1:0] d_hit,
    input logic [1:0] en_vec,
    input logic       chain_q,
    input logic       brk_req
);
    logic clr_now;
    assign clr_now = cfg_we && cfg_unit && (cfg_idx == 3'd4);

    a_r10_brk_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (brk_req == $past(|(ac_hit & d_hit & en_vec))));

    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(|en_vec));

    a_r8_chain_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> !chain_q);

    a_r7_chain_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_now && ac_hit[1]) |=> (chain_q == $past(d_hit[1])));

    a_r7_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_now && !ac_hit[1]) |=> $stable(chain_q));
endmodule

bind dwp_top dwp_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_unit (cfg_unit),
    .cfg_idx  (cfg_idx),
    .ac_hit   (ac_hit),
    .d_hit    (d_hit),
    .en_vec   (en_vec),
    .chain_q  (chain_q),
    .brk_req  (brk_req)
);

// File: tb/dwp_top_tb_top.sv
module dwp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = 32'hDEAD0000;
    logic [31:0] bus_data = '0;
    logic [5:0]  bus_attr = '0;
    logic [1:0]  ext_cond = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_unit = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        brk_req;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    bit    run_chk = 0;
    string cur_req = "R11";

    always #4 clk = ~clk;

    dwp_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_attr(bus_attr), .ext_cond(ext_cond), .cfg_we(cfg_we),
        .cfg_unit(cfg_unit), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .brk_req(brk_req)
    );

    // behavioural reference
    logic [31:0] m_reg [2][6];
    bit          m_en [2];
    bit          m_chain;
    bit          exp_brk;

    function automatic bit same_bits(input logic [31:0] x, input logic [31:0] v,
                                     input logic [31:0] m, input int n);
        for (int i = 0; i < n; i++)
            if (!m[i] && (x[i] !== v[i])) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int u = 0; u < 2; u++) begin
                for (int r = 0; r < 6; r++) m_reg[u][r] = '0;
                m_en[u] = 0;
            end
            m_chain = 0;
            exp_brk = 0;
        end else begin
            bit ac1, dh1, full0, full1;
            logic [31:0] a1, a0;
            a1 = {23'd0, 1'b0, 1'b0, ext_cond[1], bus_attr};
            ac1 = same_bits(bus_addr, m_reg[1][0], m_reg[1][1], 32)
                  && same_bits(a1, m_reg[1][4], m_reg[1][5], 9);
            dh1 = same_bits(bus_data, m_reg[1][2], m_reg[1][3], 32);
            a0 = {23'd0, ac1, m_chain, ext_cond[0], bus_attr};
            full0 = same_bits(bus_addr, m_reg[0][0], m_reg[0][1], 32)
                    && same_bits(a0, m_reg[0][4], m_reg[0][5], 9)
                    && same_bits(bus_data, m_reg[0][2], m_reg[0][3], 32);
            full1 = ac1 && dh1;
            exp_brk = (full0 && m_en[0]) || (full1 && m_en[1]);
            if (cfg_we && cfg_unit && cfg_idx == 3'd4) m_chain = 0;
            else if (ac1) m_chain = dh1;
            if (cfg_we && cfg_idx < 3'd6) begin
                if (cfg_idx == 3'd4) begin
                    m_reg[cfg_unit][4] = {23'd0, cfg_wdata[8:0]};
                    m_en[cfg_unit] = cfg_wdata[9];
                end else if (cfg_idx == 3'd5) begin
                    m_reg[cfg_unit][5] = {23'd0, cfg_wdata[8:0]};
                end else begin
                    m_reg[cfg_unit][cfg_idx] = cfg_wdata;
                end
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: brk_req=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_chk && rst_n && !done) chk({cur_req, " model"}, brk_req, exp_brk);
    end

    // one bus cycle, optionally with a register write; returns at the next negedge
    task automatic cyc(input bit we, input bit unit, input int idx, input logic [31:0] wd,
                       input logic [31:0] a, input logic [31:0] d, input logic [5:0] at,
                       input logic [1:0] ex);
        cfg_we = we; cfg_unit = unit; cfg_idx = 3'(idx); cfg_wdata = wd;
        bus_addr = a; bus_data = d; bus_attr = at; ext_cond = ex;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic bus(input logic [31:0] a, input logic [31:0] d,
                       input logic [5:0] at, input logic [1:0] ex);
        cyc(0, 0, 0, 0, a, d, at, ex);
    endtask

    task automatic idle();
        bus(32'hDEAD0000, 0, 0, 0);
    endtask

    task automatic wr(input bit unit, input int idx, input logic [31:0] wd);
        cyc(1, unit, idx, wd, 32'hDEAD0000, 0, 0, 0);
    endtask

    task automatic setw(input bit unit, input logic [31:0] av, input logic [31:0] am,
                        input logic [31:0] dv, input logic [31:0] dm,
                        input logic [31:0] cv, input logic [31:0] cm);
        wr(unit, 0, av); wr(unit, 1, am); wr(unit, 2, dv);
        wr(unit, 3, dm); wr(unit, 4, cv); wr(unit, 5, cm);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 in reset", brk_req, 1'b0);
        rst_n = 1;
        run_chk = 1;
        bus(32'h0, 32'h0, 6'h0, 2'b00);
        chk("R11 after reset all-zero bus", brk_req, 1'b0);
        bus(32'h1000, 32'h55, 6'h3F, 2'b11);
        chk("R11 after reset", brk_req, 1'b0);

        // R1 address match and mask
        cur_req = "R1";
        setw(0, 32'h1000, 0, 0, 32'hFFFFFFFF, 32'h200, 32'h1FF);
        bus(32'h1000, 32'h1234, 6'h15, 2'b00);
        chk("R1 exact address", brk_req, 1'b1);
        bus(32'h1004, 32'h1234, 6'h15, 2'b00);
        chk("R1 address miss", brk_req, 1'b0);
        wr(0, 1, 32'hF);
        bus(32'h100C, 0, 0, 0);
        chk("R1 masked low bits", brk_req, 1'b1);
        bus(32'h101C, 0, 0, 0);
        chk("R1 unmasked bit differs", brk_req, 1'b0);

        // R2 data
        cur_req = "R2";
        setw(0, 32'h1000, 0, 32'hCAFE, 0, 32'h200, 32'h1FF);
        bus(32'h1000, 32'hCAFE, 0, 0);
        chk("R2 data hit", brk_req, 1'b1);
        bus(32'h1000, 32'hCAFF, 0, 0);
        chk("R2 data miss", brk_req, 1'b0);

        // R3/R5 attribute bits
        cur_req = "R3";
        setw(0, 32'h1000, 0, 0, 32'hFFFFFFFF, 32'h208, 32'h1F7);
        bus(32'h1000, 0, 6'h08, 0);
        chk("R3 data access bit3=1", brk_req, 1'b1);
        bus(32'h1000, 0, 6'h00, 0);
        chk("R3 fetch bit3=0 rejected", brk_req, 1'b0);
        wr(0, 4, 32'h200); wr(0, 5, 32'h1EF); idle();
        bus(32'h1000, 0, 6'h00, 0);
        chk("R3 User mode bit4=0", brk_req, 1'b1);
        bus(32'h1000, 0, 6'h10, 0);
        chk("R3 privileged bit4=1 rejected", brk_req, 1'b0);
        cur_req = "R5";
        wr(0, 5, 32'h1FF); idle();
        bus(32'h1000, 0, 6'h3F, 0);
        chk("R5 all attribute bits masked", brk_req, 1'b1);

        // R4 external condition
        cur_req = "R4";
        wr(0, 4, 32'h240); wr(0, 5, 32'h1BF); idle();
        bus(32'h1000, 0, 0, 2'b01);
        chk("R4 ext0 high", brk_req, 1'b1);
        bus(32'h1000, 0, 0, 2'b00);
        chk("R4 ext0 low", brk_req, 1'b0);
        bus(32'h1000, 0, 0, 2'b10);
        chk("R4 ext1 ignored by unit 0", brk_req, 1'b0);

        // R6 enable
        cur_req = "R6";
        wr(0, 4, 32'h000); wr(0, 5, 32'h1FF); idle();
        bus(32'h1000, 0, 0, 0);
        chk("R6 disabled unit quiet", brk_req, 1'b0);
        wr(0, 4, 32'h200); idle();
        bus(32'h1000, 0, 0, 0);
        chk("R6 enabled again", brk_req, 1'b1);

        // R7 chain
        cur_req = "R7";
        setw(1, 32'h2000, 0, 32'h55, 0, 32'h000, 32'h1FF);
        setw(0, 32'h1000, 0, 0, 32'hFFFFFFFF, 32'h280, 32'h17F);
        bus(32'h1000, 0, 0, 0);
        chk("R7 chain clear blocks", brk_req, 1'b0);
        bus(32'h2000, 32'h55, 0, 0);
        chk("R7 loading cycle", brk_req, 1'b0);
        bus(32'h1000, 0, 0, 0);
        chk("R7 chain set", brk_req, 1'b1);
        bus(32'h3000, 32'h99, 0, 0);
        bus(32'h1000, 0, 0, 0);
        chk("R7 chain holds", brk_req, 1'b1);
        bus(32'h2000, 32'h66, 0, 0);
        bus(32'h1000, 0, 0, 0);
        chk("R7 chain reloaded with data miss", brk_req, 1'b0);

        // R8 clear by write, wins over load
        cur_req = "R8";
        bus(32'h2000, 32'h55, 0, 0);
        bus(32'h1000, 0, 0, 0);
        chk("R8 chain set before clear", brk_req, 1'b1);
        cyc(1, 1, 4, 32'h000, 32'h2000, 32'h55, 0, 0);
        bus(32'h1000, 0, 0, 0);
        chk("R8 clear wins over load", brk_req, 1'b0);

        // R7 unit 1 coupling terms read 0
        cur_req = "R7";
        setw(0, 0, 0, 0, 0, 32'h000, 32'h1FF);
        setw(1, 32'h2000, 0, 0, 32'hFFFFFFFF, 32'h200, 32'h07F);
        bus(32'h2000, 0, 0, 0);
        chk("R7 unit 1 bits 8:7 zero match", brk_req, 1'b1);
        wr(1, 4, 32'h280); idle();
        bus(32'h2000, 0, 0, 0);
        chk("R7 unit 1 chain term never 1", brk_req, 1'b0);

        // R9 range
        cur_req = "R9";
        setw(1, 32'h2000, 0, 0, 32'hFFFFFFFF, 32'h000, 32'h1FF);
        setw(0, 0, 32'hFFFFFFFF, 0, 32'hFFFFFFFF, 32'h300, 32'h0FF);
        bus(32'h2000, 0, 0, 0);
        chk("R9 range term from unit 1", brk_req, 1'b1);
        bus(32'h2004, 0, 0, 0);
        chk("R9 range term low", brk_req, 1'b0);
        wr(1, 1, 32'hF); idle();
        bus(32'h2004, 0, 0, 0);
        chk("R9 unit 1 mask widens range", brk_req, 1'b1);

        // R10 unit 1 alone, back-to-back
        cur_req = "R10";
        setw(0, 0, 0, 0, 0, 32'h000, 32'h1FF);
        setw(1, 32'h2000, 0, 0, 32'hFFFFFFFF, 32'h200, 32'h1FF);
        bus(32'h2000, 0, 0, 0);
        chk("R10 unit 1 break", brk_req, 1'b1);
        bus(32'h2000, 0, 0, 0);
        chk("R10 second consecutive break", brk_req, 1'b1);
        idle();
        chk("R10 break drops", brk_req, 1'b0);

        // R12 write timing
        cur_req = "R12";
        setw(1, 0, 0, 0, 0, 32'h000, 32'h1FF);
        setw(0, 0, 0, 0, 32'hFFFFFFFF, 32'h200, 32'h1FF);
        cyc(1, 0, 0, 32'h5000, 32'h5000, 0, 0, 0);
        chk("R12 write not used in its own cycle", brk_req, 1'b0);
        bus(32'h5000, 0, 0, 0);
        chk("R12 write used next cycle", brk_req, 1'b1);

        // random mix checked against the model every cycle
        cur_req = "R10";
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] pool_a [4];
            logic [31:0] pool_d [4];
            logic [31:0] wd;
            int idx;
            bit we;
            pool_a[0] = 32'h1000; pool_a[1] = 32'h2000; pool_a[2] = 32'h2004; pool_a[3] = 32'h100C;
            pool_d[0] = 32'h55; pool_d[1] = 32'hCAFE; pool_d[2] = 32'h66; pool_d[3] = $urandom;
            we = ($urandom % 8) == 0;
            idx = $urandom % 6;
            case (idx)
                0: wd = pool_a[$urandom % 4];
                1: wd = $urandom % 16;
                2: wd = pool_d[$urandom % 3];
                3: wd = (($urandom % 2) == 0) ? 32'hFFFFFFFF : 32'h0;
                4: wd = $urandom % 1024;
                default: wd = ($urandom | $urandom | $urandom) & 32'h1FF;
            endcase
            cyc(we, 1'($urandom), idx, wd, pool_a[$urandom % 4], pool_d[$urandom % 4],
                6'($urandom), 2'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog: run did not end, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule